// File: doc/BRIEF.md
# Multi-Level Priority Bus Arbiter

This block is the central arbiter for a shared PCI-style bus with nine masters. Each master has an active-low request line and gets an active-low grant line back. On every clock the arbiter registers all requests and chooses a winner, whatever the bus is doing at the time. It drives at most one grant. It also watches the bus cycle-frame signal so that it knows when a granted master has actually claimed the bus.

Each master is placed in one of three priority levels (low, medium, high) by its own 2-bit code. Masters on the same level take turns in round-robin order. The turn moves on only when a master really starts a transaction, not when it is merely granted. A grant that has not yet been used can be taken back by a better requester.

When a master claims the bus, the strongest requester that lost the current round can be lifted into a single reserved slot, provided the slot is empty. The master in the slot beats every level. When no master is requesting, the grant stays parked on the last owner. Every change of owner passes through exactly one cycle in which no grant is driven.

Top module: `mlvl_bus_arbiter`

## Requirements
- R1: While reset is held every grant is high. Once reset is released with no request pending, the first clock edge parks the grant on master 0.
- R2: A request that changes before clock edge k is registered at edge k. If a different master holds the grant, that grant is removed at edge k+1 and the new winner's grant goes low at edge k+2.
- R3: At most one grant is low in any cycle. A change of owner always passes through exactly one cycle with all grants high, so a grant is never swapped directly from one master to another.
- R4: Each master has a 2-bit priority code: bits [2i+1:2i] of the priority input belong to master i. Code 00 means low, 01 means medium, and 10 or 11 means high. A requester on a higher level always beats requesters on lower levels.
- R5: Within one level the winner is the first requester found after that level's pointer, counting upward and wrapping past master 8. The pointer starts at master 8. It moves to a master when that master claims the bus.
- R6: If a higher-priority master requests before the current grant holder has claimed the bus, the current grant is removed and the new master is granted one clock later.
- R7: If the grant holder withdraws its request while another master is requesting, the grant moves to that other master through the dead cycle.
- R8: While no master requests, the grant stays on the current owner, whatever the bus is doing.
- R9: A claim happens when frame is sampled low, after being high on the previous edge, while a grant is driven. On a claim with the reserved slot empty, the highest-level round winner other than the claiming master is placed in the slot. A claim that finds the slot full changes nothing in it. A requesting slot master beats all levels. The slot is emptied when its own master claims the bus.
- R10: If frame is sampled low on the same edge at which the arbiter removes a grant, the master losing the grant is still counted as having claimed the bus, and its level pointer moves to it.
- R11: Requests are sampled and arbitrated the same way whether frame is asserted or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | 9 | Active-low request, one bit per master |
| prioCode | input | 18 | Two-bit priority code per master (00 low, 01 medium, 1x high) |
| frameN | input | 1 | Active-low bus cycle frame, observed for claims |
| gntN | output | 9 | Active-low grant, one bit per master |

## Verification
Requests pass through one register before arbitration, so a request change made before edge k leaves the grant unchanged after edge k, drops the old grant after edge k+1 and shows the new grant after edge k+2. The bench drives inputs and samples grants on the falling edge and checks these three points exactly in its single-requester sweep and its preemption case. A claim is recorded at the edge where frame is sampled low. Its effect on pointers and the reserved slot is seen no earlier than two edges later, so checks of arbitration order wait four cycles after each claim pulse and compare against a steady grant. A falling-edge monitor checks the one-grant and dead-cycle rules on every cycle of every sweep.

// File: rtl/mlvl_arb_pkg.sv
package mlvl_arb_pkg;

  localparam int LvlCount = 3;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MED  = 2'd1,
    LVL_HIGH = 2'd2
  } arbLevel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holding;   // a grant is being driven
    logic grantNow;  // load the next owner this edge
    logic claimNow;  // grant holder starts a transaction this edge
  } arbStrobe_t;

endpackage

// File: rtl/mlvl_arb_dpath.sv
module mlvl_arb_dpath
  import mlvl_arb_pkg::*;
#(
  parameter int NumMasters = 9,
  localparam int IdxW = $clog2(NumMasters)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NumMasters-1:0]   reqN,
  input  logic [2*NumMasters-1:0] prioCode,
  input  arbStrobe_t              stb,
  output logic                    winDiffers,
  output logic [NumMasters-1:0]   gntN
);

  logic [NumMasters-1:0] reqQ;
  arbLevel_t             lvlOf [NumMasters];
  logic [IdxW-1:0]       rrPtr [LvlCount];
  logic [IdxW-1:0]       ownerIdx;
  logic                  slotValid;
  logic [IdxW-1:0]       slotIdx;
  logic [NumMasters-1:0] ownerOneHot;

  logic [LvlCount-1:0]   pickValid;
  logic [IdxW-1:0]       pickIdx [LvlCount];
  logic [LvlCount-1:0]   promValid;
  logic [IdxW-1:0]       promIdx [LvlCount];

  logic                  winValid;
  logic [IdxW-1:0]       winIdx;
  logic                  promAny;
  logic [IdxW-1:0]       promPick;
  logic                  slotReq;

  // first set bit strictly after ptr, wrapping; result {found, index}
  function automatic logic [IdxW:0] rrSelect(input logic [NumMasters-1:0] mask,
                                             input logic [IdxW-1:0] ptr);
    logic [IdxW:0] res;
    res = '0;
    for (int k = NumMasters; k >= 1; k--) begin
      int j;
      j = int'(ptr) + k;
      if (j >= NumMasters) j = j - NumMasters;
      if (mask[j]) res = {1'b1, j[IdxW-1:0]};
    end
    return res;
  endfunction

  always_comb begin
    for (int i = 0; i < NumMasters; i++) begin
      if (prioCode[2*i+1])     lvlOf[i] = LVL_HIGH;
      else if (prioCode[2*i])  lvlOf[i] = LVL_MED;
      else                     lvlOf[i] = LVL_LOW;
    end
  end

  assign ownerOneHot = {{(NumMasters-1){1'b0}}, 1'b1} << ownerIdx;

  // one round-robin picker per level, plus one that skips the owner
  for (genvar l = 0; l < LvlCount; l++) begin : gLevel
    logic [NumMasters-1:0] lvlMask;
    logic [NumMasters-1:0] exMask;
    always_comb begin
      for (int i = 0; i < NumMasters; i++) begin
        lvlMask[i] = reqQ[i] && (lvlOf[i] == arbLevel_t'(l));
      end
      exMask = lvlMask & ~ownerOneHot;
    end
    assign {pickValid[l], pickIdx[l]} = rrSelect(lvlMask, rrPtr[l]);
    assign {promValid[l], promIdx[l]} = rrSelect(exMask, rrPtr[l]);
  end

  assign slotReq = slotValid && reqQ[slotIdx];

  always_comb begin
    winValid = 1'b0;
    winIdx   = ownerIdx;
    for (int l = 0; l < LvlCount; l++) begin
      if (pickValid[l]) begin
        winValid = 1'b1;
        winIdx   = pickIdx[l];
      end
    end
    if (slotReq) begin
      winValid = 1'b1;
      winIdx   = slotIdx;
    end
  end

  always_comb begin
    promAny  = 1'b0;
    promPick = '0;
    for (int l = 0; l < LvlCount; l++) begin
      if (promValid[l]) begin
        promAny  = 1'b1;
        promPick = promIdx[l];
      end
    end
  end

  assign winDiffers = winValid && (winIdx != ownerIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ      <= '0;
      ownerIdx  <= '0;
      slotValid <= 1'b0;
      slotIdx   <= '0;
      for (int l = 0; l < LvlCount; l++) rrPtr[l] <= IdxW'(NumMasters - 1);
    end else begin
      reqQ <= ~reqN;
      if (stb.grantNow && winValid) ownerIdx <= winIdx;
      if (stb.claimNow) begin
        rrPtr[lvlOf[ownerIdx]] <= ownerIdx;
        if (slotValid && (slotIdx == ownerIdx)) begin
          slotValid <= 1'b0;
        end else if (!slotValid && promAny) begin
          slotValid <= 1'b1;
          slotIdx   <= promPick;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NumMasters; i++) begin
      gntN[i] = !(stb.holding && (ownerIdx == IdxW'(i)));
    end
  end

endmodule

// File: rtl/mlvl_arb_ctrl.sv
module mlvl_arb_ctrl
  import mlvl_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       winDiffers,
  output arbStrobe_t stb
);

  typedef enum logic {ST_GAP, ST_HELD} ctrlState_t;

  ctrlState_t state, stateNext;
  logic       frameQ;
  logic       dropNow;

  assign dropNow = (state == ST_HELD) && winDiffers;

  always_comb begin
    stb.holding  = (state == ST_HELD);
    stb.grantNow = (state == ST_GAP);
    stb.claimNow = (state == ST_HELD) && !frameN && frameQ;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_GAP:  stateNext = ST_HELD;
      ST_HELD: if (dropNow) stateNext = ST_GAP;
      default: stateNext = ST_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_GAP;
      frameQ <= 1'b1;
    end else begin
      state  <= stateNext;
      frameQ <= frameN;
    end
  end

endmodule

// File: rtl/mlvl_bus_arbiter.sv
module mlvl_bus_arbiter
  import mlvl_arb_pkg::*;
#(
  parameter int NumMasters = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NumMasters-1:0]   reqN,
  input  logic [2*NumMasters-1:0] prioCode,
  input  logic                    frameN,
  output logic [NumMasters-1:0]   gntN
);

  arbStrobe_t stb;
  logic       winDiffers;

  mlvl_arb_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameN     (frameN),
    .winDiffers (winDiffers),
    .stb        (stb)
  );

  mlvl_arb_dpath #(.NumMasters(NumMasters)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .reqN       (reqN),
    .prioCode   (prioCode),
    .stb        (stb),
    .winDiffers (winDiffers),
    .gntN       (gntN)
  );

endmodule

// File: rtl/mlvl_arb_chk.sv
module mlvl_arb_chk #(
  parameter int NumMasters = 9
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NumMasters-1:0] reqN,
  input logic [NumMasters-1:0] gntN
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (gntN == '1) else $error("grant driven in reset");
    end
  end

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gntN));

  // R3
  handover_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gntN != '1 && !$stable(gntN)) |-> ($past(gntN) == '1));

  // R3
  gap_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gntN == '1 && $past(gntN) != '1) |=> (gntN != '1));

  // R8
  park_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gntN != '1 && $past(reqN) == '1) |=> $stable(gntN));

endmodule

bind mlvl_bus_arbiter mlvl_arb_chk #(.NumMasters(NumMasters)) uChk (
  .clk  (clk),
  .rstN (rstN),
  .reqN (reqN),
  .gntN (gntN)
);

// File: tb/sim_mlvl_bus_arbiter.sv
module sim_mlvl_bus_arbiter;

  localparam int N = 9;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   reqN = '1;
  logic [2*N-1:0] prioCode = '0;
  logic           frameN = 1'b1;
  logic [N-1:0]   gntN;

  int nChecks = 0;
  int nFail = 0;
  logic [N-1:0] prevG = '1;

  always #10 clk = ~clk;  // 50 MHz

  mlvl_bus_arbiter #(.NumMasters(N)) u0 (
    .clk(clk), .rstN(rstN), .reqN(reqN), .prioCode(prioCode),
    .frameN(frameN), .gntN(gntN)
  );

  function automatic logic [N-1:0] gOf(input int i);
    return ~({{(N-1){1'b0}}, 1'b1} << i);
  endfunction

  function automatic logic [N-1:0] rOf(input logic [N-1:0] set);
    return ~set;
  endfunction

  task automatic chk(input logic [N-1:0] exp, input string tag);
    nChecks++;
    if (gntN !== exp) begin
      nFail++;
      $display("FAIL %s: gnt=%b expected %b", tag, gntN, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic claimPulse();
    frameN = 1'b0;
    step(1);
    frameN = 1'b1;
  endtask

  task automatic doReset();
    rstN = 1'b0; reqN = '1; frameN = 1'b1; prioCode = '0;
    step(3);
    chk('1, "R1 reset quiet");
    rstN = 1'b1;
    step(1);
    chk(gOf(0), "R1 park on master 0");
  endtask

  // R3 monitor: one grant at most, no direct swap
  always @(negedge clk) begin
    if (!rstN) begin
      prevG <= '1;
    end else begin
      nChecks++;
      if ($countones(~gntN) > 1 ||
          (prevG != '1 && gntN != '1 && gntN != prevG)) begin
        nFail++;
        $display("FAIL R3: gnt=%b after %b expected one grant with gap", gntN, prevG);
      end
      prevG <= gntN;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    int owner;
    logic [N-1:0] set;
    int exp;

    doReset();

    // R2 / R8 / R11: lone requester sweep, frame toggled across iterations
    owner = 0;
    for (int s = 1; s <= N; s++) begin
      int i;
      i = s % N;
      frameN = (s % 2 == 1) ? 1'b0 : 1'b1;
      reqN = gOf(i);
      step(1);
      chk(gOf(owner), "R2 no change at sampling edge");
      step(1);
      chk('1, "R2 old grant dropped (R11 frame independent)");
      step(1);
      chk(gOf(i), "R2 new grant two edges after sampling");
      reqN = '1;
      step(3);
      chk(gOf(i), "R8 parked with no requests");
      owner = i;
    end
    frameN = 1'b1;

    // R4: every ordered pair, high vs medium and medium vs low
    doReset();
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          if (a != b) begin
            prioCode = '0;
            prioCode[2*a +: 2] = (c == 0) ? ((a % 2 == 1) ? 2'b11 : 2'b10) : 2'b01;
            prioCode[2*b +: 2] = (c == 0) ? 2'b01 : 2'b00;
            set = '0; set[a] = 1'b1; set[b] = 1'b1;
            reqN = rOf(set);
            step(5);
            chk(gOf(a), "R4 higher level wins");
            reqN = '1;
            step(2);
          end
        end
      end
    end

    // R5: round robin among 1, 4, 7 at low level, moved by claims
    doReset();
    set = '0; set[1] = 1'b1; set[4] = 1'b1; set[7] = 1'b1;
    reqN = rOf(set);
    exp = N - 1;
    for (int t = 0; t < 6; t++) begin
      int nx;
      nx = -1;
      for (int k = N; k >= 1; k--) begin
        int j;
        j = (exp + k) % N;
        if (set[j]) nx = j;
      end
      exp = nx;
      step(4);
      chk(gOf(exp), "R5 round-robin turn after claim");
      claimPulse();
    end
    reqN = '1;
    step(2);

    // R9 / R7: promotion slot
    doReset();
    prioCode[2*2 +: 2] = 2'b10;
    prioCode[2*5 +: 2] = 2'b01;
    set = '0; set[2] = 1'b1; set[5] = 1'b1; set[6] = 1'b1;
    reqN = rOf(set);
    step(5);
    chk(gOf(2), "R4 high requester first");
    claimPulse(); step(4);
    chk(gOf(5), "R9 promoted medium beats high");
    claimPulse(); step(4);
    chk(gOf(2), "R9 slot emptied by its own claim");
    claimPulse(); step(4);
    chk(gOf(5), "R9 promoted again into empty slot");
    set[5] = 1'b0; reqN = rOf(set);
    step(4);
    chk(gOf(2), "R7 owner withdrew, grant moves on");
    claimPulse(); step(4);
    chk(gOf(2), "R9 full slot blocks promotion of low requester");
    set[5] = 1'b1; reqN = rOf(set);
    step(4);
    chk(gOf(5), "R9 slot entry kept and wins");
    reqN = '1;
    step(2);

    // R6: preemption before claim
    doReset();
    prioCode[2*8 +: 2] = 2'b10;
    reqN = gOf(3);
    step(4);
    chk(gOf(3), "R6 low master granted");
    reqN = rOf((~gOf(3)) | (~gOf(8)));
    step(1);
    chk(gOf(3), "R6 unchanged at sampling edge");
    step(1);
    chk('1, "R6 unclaimed grant removed");
    step(1);
    chk(gOf(8), "R6 high master granted one clock later");
    reqN = '1;
    step(2);

    // R10: frame on the removal edge still counts as a claim by master 3
    doReset();
    prioCode[2*8 +: 2] = 2'b10;
    reqN = gOf(3);
    step(4);
    chk(gOf(3), "R10 setup grant to 3");
    reqN = rOf((~gOf(3)) | (~gOf(8)));
    step(1);
    frameN = 1'b0;
    step(1);
    chk('1, "R10 grant removed on frame edge");
    frameN = 1'b1;
    step(1);
    chk(gOf(8), "R10 next owner granted");
    reqN = '1;
    step(3);
    reqN = rOf((~gOf(3)) | (~gOf(4)));
    step(4);
    chk(gOf(4), "R10 pointer moved to master 3, so 4 wins");
    reqN = '1;
    step(2);

    summary();
    $finish;
  end

endmodule